// File: doc/BRIEF.md
# Interrupt Recognizer

This block sits beside an instruction sequencer. At every instruction boundary it decides whether an interrupt is taken, and if so which vector type is used. It weighs four sources: an internal divide-by-zero exception, a software interrupt that carries its own 8-bit type, a non-maskable request pin, and a maskable request pin. The maskable pin is gated by the interrupt-enable flag. A taken interrupt shows up as a one-cycle pulse, together with the 8-bit type and the vector table byte address, which is the type times four.

The non-maskable pin is edge-triggered. Its rising edge is held in a pending latch, so a short pulse that falls between two boundaries is still served. The maskable pin is level-sensitive. When it wins, the block runs an acknowledge handshake: two active-low pulses, separated by a high gap. The external device returns the type number on the low data byte during the second pulse. Saving the return context and running the service routine belong to other blocks.

Top module: `irq_recognizer`

## Requirements
- R1: While reset is held and just after it, `takeInt` is 0, `intaN` is 1, and `intType` and `vecAddr` are 0.
- R2: When `divZero` is high in a boundary cycle, the next cycle pulses `takeInt` with type 0. This source wins over every other source.
- R3: When `swReq` is high in a boundary cycle and there is no divide exception, the next cycle pulses `takeInt` with the type taken from `swType`. This source wins over the non-maskable and maskable requests.
- R4: A rising edge on `nmiPin` is latched even when no boundary is present. At the next boundary where no divide or software request is present, it is taken with type 2, whatever the value of `ieFlag`. It wins over the maskable request.
- R5: The non-maskable latch clears only when its interrupt is taken. A level held high does not trigger a second take; a new rising edge is needed.
- R6: A maskable request (`intrPin` high with `ieFlag` high) that wins at a boundary causes the following sequence. `intaN` goes low for ACK_LOW_CYCLES cycles, high for ACK_GAP_CYCLES cycles, then low again for ACK_LOW_CYCLES cycles. The type is taken from `dataBus` on the last cycle of the second low pulse. `takeInt` pulses in the next cycle. With the default parameters, `takeInt` is high 5 cycles after the first low cycle of `intaN`.
- R7: When `ieFlag` is 0, the maskable request is ignored: `takeInt` stays low and `intaN` stays high.
- R8: No interrupt is taken without a boundary. `takeInt` is never high in two consecutive cycles, and a boundary in the same cycle as a take pulse is ignored.
- R9: `vecAddr` equals `intType` multiplied by 4, as a 10-bit byte address in the range 0 to 3FFh. Both hold their values until the next take.
- R10: Boundaries and exceptions that arrive during an acknowledge sequence are ignored. A non-maskable edge that arrives in that time stays latched and is taken at the first boundary after the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| nmiPin | input | 1 | Non-maskable request, rising-edge triggered |
| intrPin | input | 1 | Maskable request, level-sensitive |
| ieFlag | input | 1 | Interrupt-enable flag |
| instrBoundary | input | 1 | High for one cycle at an instruction boundary |
| divZero | input | 1 | Divide-by-zero exception, sampled at the boundary |
| swReq | input | 1 | Software interrupt request, sampled at the boundary |
| swType | input | 8 | Type number of the software interrupt |
| dataBus | input | 8 | Low data byte, read during the acknowledge sequence |
| takeInt | output | 1 | One-cycle pulse when an interrupt is taken |
| intType | output | 8 | Type of the last taken interrupt |
| vecAddr | output | 10 | Vector table byte address, equal to the type times 4 |
| intaN | output | 1 | Active-low acknowledge toward the device |

## Verification
The assertions check the following on every cycle:
- a rising edge on the non-maskable pin is latched;
- the latch holds until its interrupt is taken;
- the take pulse lasts a single cycle;
- the type holds between loads;
- the acknowledge line stays high while idle with interrupts disabled, and during the gap.

Only the directed scenarios can show the priority order between sources that are pending together, the exact cycle at which the take pulse appears after a two-pulse acknowledge, the capture of the type from the bus during the second pulse and not the first, and the survival of a non-maskable edge across an acknowledge sequence.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [1:0] {
    SRC_DIV = 2'd0,
    SRC_SW  = 2'd1,
    SRC_NMI = 2'd2,
    SRC_BUS = 2'd3
  } srcSel_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACK1 = 2'd1,
    ST_GAP  = 2'd2,
    ST_ACK2 = 2'd3
  } ackState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    loadType;
    srcSel_t src;
    logic    clrNmi;
    logic    fire;
  } ctlStrobes_t;

endpackage

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int TYPE_W   = 8,
  parameter int DIV_TYPE = 0,
  parameter int NMI_TYPE = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              nmiPin,
  input  logic [TYPE_W-1:0] swType,
  input  logic [TYPE_W-1:0] dataBus,
  input  ctlStrobes_t       st,
  output logic              nmiPend,
  output logic              takeInt,
  output logic [TYPE_W-1:0] intType,
  output logic [TYPE_W+1:0] vecAddr
);

  localparam int ADDR_W = TYPE_W + 2;

  logic              nmiPrev;
  logic              nmiEdge;
  logic [TYPE_W-1:0] nextType;

  assign nmiEdge = nmiPin & ~nmiPrev;

  // edge latch: a new edge wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      nmiPrev <= 1'b1;
      nmiPend <= 1'b0;
    end else begin
      nmiPrev <= nmiPin;
      if (nmiEdge)        nmiPend <= 1'b1;
      else if (st.clrNmi) nmiPend <= 1'b0;
    end
  end

  always_comb begin
    unique case (st.src)
      SRC_DIV: nextType = TYPE_W'(DIV_TYPE);
      SRC_SW:  nextType = swType;
      SRC_NMI: nextType = TYPE_W'(NMI_TYPE);
      default: nextType = dataBus;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intType <= '0;
      takeInt <= 1'b0;
    end else begin
      takeInt <= st.fire;
      if (st.loadType) intType <= nextType;
    end
  end

  assign vecAddr = ADDR_W'({intType, 2'b00});

  AST_NMI_SET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nmiPin) && $past(rstN) |=> nmiPend) else $error("nmi edge lost"); // R4

  AST_NMI_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    nmiPend && !st.clrNmi |=> nmiPend) else $error("nmi latch dropped"); // R5

  AST_TAKE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    takeInt |=> !takeInt) else $error("take longer than one cycle"); // R8

  AST_TYPE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !st.loadType |=> $stable(intType)) else $error("type changed without load"); // R9

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int ACK_LOW_CYCLES = 2,
  parameter int ACK_GAP_CYCLES = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        instrBoundary,
  input  logic        divZero,
  input  logic        swReq,
  input  logic        intrPin,
  input  logic        ieFlag,
  input  logic        nmiPend,
  input  logic        takeInt,
  output ctlStrobes_t st,
  output logic        intaN
);

  localparam int MAX_CNT = (ACK_LOW_CYCLES > ACK_GAP_CYCLES) ? ACK_LOW_CYCLES : ACK_GAP_CYCLES;
  localparam int CNT_W   = (MAX_CNT < 2) ? 1 : $clog2(MAX_CNT);
  localparam logic [CNT_W-1:0] LOW_LAST = CNT_W'(ACK_LOW_CYCLES - 1);
  localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(ACK_GAP_CYCLES - 1);

  ackState_t        state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;
  logic             decide;

  assign decide = (state == ST_IDLE) && instrBoundary && !takeInt;

  always_comb begin
    st        = '0;
    nextState = state;
    nextCnt   = cnt;
    unique case (state)
      ST_IDLE: begin
        if (decide) begin
          if (divZero) begin
            st.loadType = 1'b1;
            st.src      = SRC_DIV;
            st.fire     = 1'b1;
          end else if (swReq) begin
            st.loadType = 1'b1;
            st.src      = SRC_SW;
            st.fire     = 1'b1;
          end else if (nmiPend) begin
            st.loadType = 1'b1;
            st.src      = SRC_NMI;
            st.clrNmi   = 1'b1;
            st.fire     = 1'b1;
          end else if (intrPin && ieFlag) begin
            nextState = ST_ACK1;
            nextCnt   = '0;
          end
        end
      end
      ST_ACK1: begin
        if (cnt == LOW_LAST) begin
          nextState = ST_GAP;
          nextCnt   = '0;
        end else begin
          nextCnt = cnt + 1'b1;
        end
      end
      ST_GAP: begin
        if (cnt == GAP_LAST) begin
          nextState = ST_ACK2;
          nextCnt   = '0;
        end else begin
          nextCnt = cnt + 1'b1;
        end
      end
      default: begin
        if (cnt == LOW_LAST) begin
          st.loadType = 1'b1;
          st.src      = SRC_BUS;
          st.fire     = 1'b1;
          nextState   = ST_IDLE;
          nextCnt     = '0;
        end else begin
          nextCnt = cnt + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      intaN <= 1'b1;
    end else begin
      state <= nextState;
      cnt   <= nextCnt;
      intaN <= !((nextState == ST_ACK1) || (nextState == ST_ACK2));
    end
  end

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) && !ieFlag |=> intaN) else $error("ack while disabled"); // R7

  AST_GAP_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GAP) |-> intaN) else $error("ack low in gap"); // R6

endmodule

// File: rtl/irq_recognizer.sv
module irq_recognizer
  import irq_pkg::*;
#(
  parameter int TYPE_W         = 8,
  parameter int ACK_LOW_CYCLES = 2,
  parameter int ACK_GAP_CYCLES = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              nmiPin,
  input  logic              intrPin,
  input  logic              ieFlag,
  input  logic              instrBoundary,
  input  logic              divZero,
  input  logic              swReq,
  input  logic [TYPE_W-1:0] swType,
  input  logic [TYPE_W-1:0] dataBus,
  output logic              takeInt,
  output logic [TYPE_W-1:0] intType,
  output logic [TYPE_W+1:0] vecAddr,
  output logic              intaN
);

  ctlStrobes_t st;
  logic        nmiPend;

  irq_ctrl #(
    .ACK_LOW_CYCLES(ACK_LOW_CYCLES),
    .ACK_GAP_CYCLES(ACK_GAP_CYCLES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .instrBoundary(instrBoundary), .divZero(divZero),
    .swReq(swReq), .intrPin(intrPin), .ieFlag(ieFlag), .nmiPend(nmiPend),
    .takeInt(takeInt), .st(st), .intaN(intaN)
  );

  irq_datapath #(
    .TYPE_W(TYPE_W)
  ) uData (
    .clk(clk), .rstN(rstN), .nmiPin(nmiPin), .swType(swType), .dataBus(dataBus),
    .st(st), .nmiPend(nmiPend), .takeInt(takeInt), .intType(intType), .vecAddr(vecAddr)
  );

endmodule

// File: tb/sim_irq_recognizer.sv
module sim_irq_recognizer;

  logic       clk = 1'b0;
  logic       rstN;
  logic       nmiPin, intrPin, ieFlag, instrBoundary, divZero, swReq;
  logic [7:0] swType, busVal, dataBus;
  logic       takeInt, intaN;
  logic [7:0] intType;
  logic [9:0] vecAddr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int ackPulses = 0;
  int ackBase = 0;

  always #10 clk = ~clk;

  // the device answers with junk on the first pulse and the type on the second
  always @(negedge intaN) ackPulses++;
  assign dataBus = (ackPulses - ackBase == 2) ? busVal : 8'hEE;

  irq_recognizer u0 (
    .clk(clk), .rstN(rstN), .nmiPin(nmiPin), .intrPin(intrPin), .ieFlag(ieFlag),
    .instrBoundary(instrBoundary), .divZero(divZero), .swReq(swReq), .swType(swType),
    .dataBus(dataBus), .takeInt(takeInt), .intType(intType), .vecAddr(vecAddr), .intaN(intaN)
  );

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog expired act=%0d exp=<20000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // pulse a boundary; return with the cycle after it sampled
  task automatic boundary();
    @(negedge clk); instrBoundary = 1'b1;
    @(negedge clk); instrBoundary = 1'b0;
  endtask

  task automatic expectTake(input string tag, input int typ);
    chk(takeInt == 1'b1, {tag, " take"}, takeInt, 1);
    chk(intType == typ[7:0], {tag, " type"}, intType, typ);
    chk(vecAddr == 10'(typ * 4), {"R9 ", tag, " vector"}, vecAddr, typ * 4);
    chk(intaN == 1'b1, {tag, " no ack"}, intaN, 1);
    @(negedge clk);
    chk(takeInt == 1'b0, {"R8 ", tag, " single pulse"}, takeInt, 0);
  endtask

  task automatic t_reset();
    rstN = 1'b0; nmiPin = 0; intrPin = 0; ieFlag = 0; instrBoundary = 0;
    divZero = 0; swReq = 0; swType = 0; busVal = 0;
    repeat (4) @(negedge clk);
    chk(takeInt == 0 && intaN == 1, "R1 reset outputs", {takeInt, intaN}, 1);
    rstN = 1'b1;
    @(negedge clk);
    chk(intType == 0 && vecAddr == 0, "R1 reset type", vecAddr, 0);
  endtask

  task automatic t_div();
    @(negedge clk); divZero = 1; swReq = 1; swType = 8'h55; intrPin = 1; ieFlag = 1;
    boundary();
    expectTake("R2 divide", 0);
    divZero = 0; swReq = 0; intrPin = 0;
  endtask

  task automatic t_sw();
    @(negedge clk); swReq = 1; swType = 8'h21; intrPin = 1; ieFlag = 1;
    boundary();
    expectTake("R3 software", 8'h21);
    swReq = 0; intrPin = 0;
  endtask

  task automatic t_noBoundary();
    @(negedge clk); divZero = 1; swReq = 1; swType = 8'h33;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(takeInt == 0, "R8 no take without boundary", takeInt, 0);
    end
    divZero = 0; swReq = 0;
  endtask

  task automatic t_nmi();
    // short pulse between boundaries, interrupts disabled, maskable present
    @(negedge clk); nmiPin = 1; intrPin = 1; ieFlag = 0;
    @(negedge clk); nmiPin = 0;
    repeat (3) @(negedge clk);
    boundary();
    expectTake("R4 nmi", 2);
    boundary();
    chk(takeInt == 0, "R5 latch cleared", takeInt, 0);
    // a level held high takes once
    nmiPin = 1;
    repeat (2) @(negedge clk);
    boundary();
    expectTake("R5 held level first", 2);
    boundary();
    chk(takeInt == 0, "R5 held level no retrigger", takeInt, 0);
    nmiPin = 0; intrPin = 0;
  endtask

  task automatic t_swOverNmi();
    @(negedge clk); nmiPin = 1;
    @(negedge clk); nmiPin = 0; swReq = 1; swType = 8'hC0;
    boundary();
    expectTake("R3 software over nmi", 8'hC0);
    swReq = 0;
    boundary();
    expectTake("R4 nmi after software", 2);
  endtask

  task automatic t_masked();
    @(negedge clk); intrPin = 1; ieFlag = 0;
    for (int i = 0; i < 6; i++) begin
      instrBoundary = (i % 2 == 0);
      @(negedge clk);
      chk(takeInt == 0 && intaN == 1, "R7 masked ignored", {takeInt, intaN}, 1);
    end
    instrBoundary = 0; intrPin = 0;
  endtask

  task automatic t_ack();
    int lows = 0;
    int took = -1;
    logic [7:0] typ = 0;
    logic [9:0] va = 0;
    @(negedge clk); intrPin = 1; ieFlag = 1; busVal = 8'h4A; ackBase = ackPulses;
    instrBoundary = 1;
    @(negedge clk); instrBoundary = 0;
    for (int i = 0; i < 12; i++) begin
      if (!intaN) lows++;
      if (takeInt && took < 0) begin took = i; typ = intType; va = vecAddr; end
      if (i == 1) begin instrBoundary = 1; divZero = 1; nmiPin = 1; intrPin = 0; end
      if (i == 2) begin instrBoundary = 0; divZero = 0; end
      if (i == 3) nmiPin = 0;
      @(negedge clk);
    end
    chk(took == 5, "R6 take cycle after ack", took, 5);
    chk(typ == 8'h4A, "R6 type from second pulse", typ, 8'h4A);
    chk(va == 10'h128, "R9 ack vector", va, 10'h128);
    chk(lows == 4, "R6 ack low cycles", lows, 4);
    chk(ackPulses - ackBase == 2, "R6 ack pulse count", ackPulses - ackBase, 2);
    chk(lows == 4 && took == 5, "R10 boundary during ack ignored", took, 5);
    boundary();
    expectTake("R10 nmi kept across ack", 2);
  endtask

  initial begin
    t_reset();
    t_div();
    t_sw();
    t_noBoundary();
    t_nmi();
    t_swOverNmi();
    t_masked();
    t_ack();
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end

endmodule